// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a victim page frame for replacement using the one-bit clock approximation of least-recently-used. It holds a "recently used" flag and a "modified" flag for every frame of a table, plus a pointer to the frame that was replaced last. Reference strobes from the translation path set the flags: every reference sets the used flag, and a write also sets the modified flag.

When replacement logic asks for a frame, the selector walks the table in a circle. It starts just after the last victim and looks at one frame per clock cycle. Each frame it passes over has its used flag cleared, so a frame that is not touched again before the hand comes back becomes a candidate. A per-request mode bit asks the selector to prefer a frame that is both unused and unmodified, which saves a write-back. If no such frame exists, the selector takes the first unused frame it saw. The victim's modified flag is reported with the result so that the caller can schedule the write-back.

Top module: `clock_victim_selector`

## Requirements
- R1: After reset every used and modified flag is 0, busy and victim_valid are 0, and the hand rests on frame NUM_FRAMES-1, so the first sweep looks at frame 0 first.
- R2: A cycle with ref_valid=1 sets the used flag of frame ref_idx. If ref_write=1 as well, it also sets that frame's modified flag.
- R3: repl_req is taken only when busy=0, and busy is 1 from the next cycle until the victim is reported. A repl_req held or raised while busy=1 has no effect and produces no extra victim.
- R4: A sweep looks at one frame per cycle, beginning at the frame after the hand. victim_valid is a one-cycle pulse, raised on the clock edge that ends the cycle in which the victim was examined. So if k frames are examined, it appears k edges after the accepting edge.
- R5: In the basic mode (repl_clean=0) the victim is the first examined frame whose used flag is 0. Every frame passed over has its used flag cleared.
- R6: The hand wraps from frame NUM_FRAMES-1 to frame 0. With no references arriving during the sweep, a basic sweep ends within NUM_FRAMES+1 examined frames.
- R7: After a victim is chosen, the hand rests on it, and its used and modified flags are both cleared for the incoming page.
- R8: victim_dirty gives the modified flag the victim held when it was selected.
- R9: In clean-preferred mode (repl_clean=1) the victim is the first frame examined that is both unused and unmodified. Unused but modified frames are skipped. Used frames that are passed over are cleared.
- R10: In clean-preferred mode, if a full circle of NUM_FRAMES frames finds no unused and unmodified frame, the victim is the first unused frame seen in that circle. If none was unused, the sweep goes on in basic mode.
- R11: A reference strobe to the frame under examination in the same cycle wins: that frame keeps its used flag set and is not chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_valid | input | 1 | A frame was referenced this cycle |
| ref_write | input | 1 | The reference was a write |
| ref_idx | input | IDX_W | Frame index of the reference |
| repl_req | input | 1 | Request a victim frame |
| repl_clean | input | 1 | Prefer an unused, unmodified frame for this request |
| busy | output | 1 | Sweep in progress |
| victim_valid | output | 1 | One-cycle pulse: victim_idx and victim_dirty are valid |
| victim_idx | output | IDX_W | Selected frame |
| victim_dirty | output | 1 | Modified flag of the selected frame |

## Verification
The hardest case to produce is a reference that lands on the very frame the hand is examining in that same cycle. The stimulus first brings the table to a state where the frame after the hand is unused. It then drives the request on one falling edge and the reference strobe to that frame on the next one, so that the strobe is sampled on the edge that ends the examination. A later request then shows at the ports that the frame kept its used flag. The fallback case in clean-preferred mode is reached by first making every frame modified, then running one basic sweep so that all but one frame are left unused and modified.

// File: rtl/crp_pkg.sv
// Shared types for the clock page replacement selector.
package crp_pkg;
    // Sweep controller state: waiting for a request or walking the table.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_st_t;
endpackage

// File: rtl/crp_flag_bank.sv
// Per-frame used and modified flags.
// Assumes: at most one reference per cycle. A reference always wins over a
// clear issued in the same cycle for the same frame.
module crp_flag_bank #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_valid,
    input  logic                  ref_write,
    input  logic [IDX_W-1:0]      ref_idx,
    input  logic                  clr_used_en,
    input  logic [IDX_W-1:0]      clr_used_idx,
    input  logic                  evict_en,
    input  logic [IDX_W-1:0]      evict_idx,
    output logic [NUM_FRAMES-1:0] used_vec,
    output logic [NUM_FRAMES-1:0] dirty_vec
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic hit_ref;
        logic hit_clr;
        logic hit_evict;
        assign hit_ref   = ref_valid   && (ref_idx      == IDX_W'(i));
        assign hit_clr   = clr_used_en && (clr_used_idx == IDX_W'(i));
        assign hit_evict = evict_en    && (evict_idx    == IDX_W'(i));

        // Used flag: a reference sets it; passing hand or eviction clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)                  used_vec[i] <= 1'b0;
            else if (hit_ref)            used_vec[i] <= 1'b1;
            else if (hit_clr || hit_evict) used_vec[i] <= 1'b0;
        end

        // Modified flag: a write sets it; only eviction clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)                   dirty_vec[i] <= 1'b0;
            else if (hit_ref && ref_write) dirty_vec[i] <= 1'b1;
            else if (hit_evict)            dirty_vec[i] <= 1'b0;
        end
    end

    p_ref_sets_used_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> used_vec[$past(ref_idx)]);

    p_write_sets_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_write) |=> dirty_vec[$past(ref_idx)]);

    p_evict_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_en && !(ref_valid && ref_idx == evict_idx))
        |=> (!used_vec[$past(evict_idx)] && !dirty_vec[$past(evict_idx)]));

    p_ref_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_used_en && ref_valid && ref_idx == clr_used_idx)
        |=> used_vec[$past(clr_used_idx)]);
endmodule

// File: rtl/crp_sweep_ctrl.sv
// Clock hand and sweep state machine.
// Looks at one frame per cycle, starting after the hand. It clears passed-over
// used flags and picks a victim (basic or clean-preferred policy).
// Assumes: the flag bank updates on the same edge that this block decides on.
module crp_sweep_ctrl #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  repl_req,
    input  logic                  repl_clean,
    input  logic                  ref_valid,
    input  logic [IDX_W-1:0]      ref_idx,
    input  logic [NUM_FRAMES-1:0] used_vec,
    input  logic [NUM_FRAMES-1:0] dirty_vec,
    output logic                  clr_used_en,
    output logic [IDX_W-1:0]      clr_used_idx,
    output logic                  evict_en,
    output logic [IDX_W-1:0]      evict_idx,
    output logic                  busy,
    output logic                  victim_valid,
    output logic [IDX_W-1:0]      victim_idx,
    output logic                  victim_dirty
);
    import crp_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    sweep_st_t        state_q;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] steps_q;
    logic             clean_q;
    logic             fb_valid_q;
    logic [IDX_W-1:0] fb_idx_q;

    logic             cur_used;
    logic             cur_dirty;
    logic             pick;
    logic [IDX_W-1:0] pick_idx;
    logic             advance;
    logic             rec_fb;
    logic             to_basic;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
        return (v == LAST_IDX) ? '0 : v + 1'b1;
    endfunction

    // Effective flags of the examined frame; a same-cycle reference counts as use.
    assign cur_used  = used_vec[cur_q] | (ref_valid && ref_idx == cur_q);
    assign cur_dirty = dirty_vec[cur_q];

    // Decide the action for the frame under the hand in this cycle.
    always_comb begin
        pick     = 1'b0;
        pick_idx = cur_q;
        advance  = 1'b0;
        rec_fb   = 1'b0;
        to_basic = 1'b0;
        clr_used_en = 1'b0;
        if (state_q == ST_SWEEP) begin
            if (clean_q) begin
                if (!cur_used && !cur_dirty) begin
                    pick = 1'b1;
                end else if (steps_q == LAST_IDX) begin
                    clr_used_en = cur_used;
                    if (fb_valid_q) begin
                        pick     = 1'b1;
                        pick_idx = fb_idx_q;
                    end else if (!cur_used) begin
                        pick = 1'b1;
                    end else begin
                        advance  = 1'b1;
                        to_basic = 1'b1;
                    end
                end else begin
                    clr_used_en = cur_used;
                    advance     = 1'b1;
                    rec_fb      = !cur_used && !fb_valid_q;
                end
            end else begin
                if (!cur_used) begin
                    pick = 1'b1;
                end else begin
                    clr_used_en = 1'b1;
                    advance     = 1'b1;
                end
            end
        end
    end

    assign clr_used_idx = cur_q;
    assign evict_en     = pick;
    assign evict_idx    = pick_idx;
    assign busy         = (state_q == ST_SWEEP);

    // Sweep state, hand, cursor and fallback bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hand_q     <= LAST_IDX;
            cur_q      <= '0;
            steps_q    <= '0;
            clean_q    <= 1'b0;
            fb_valid_q <= 1'b0;
            fb_idx_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (repl_req) begin
                state_q    <= ST_SWEEP;
                cur_q      <= wrap_inc(hand_q);
                steps_q    <= '0;
                clean_q    <= repl_clean;
                fb_valid_q <= 1'b0;
            end
        end else begin
            if (pick) begin
                state_q <= ST_IDLE;
                hand_q  <= pick_idx;
            end
            if (advance) begin
                cur_q   <= wrap_inc(cur_q);
                steps_q <= steps_q + 1'b1;
            end
            if (to_basic) clean_q <= 1'b0;
            if (rec_fb) begin
                fb_valid_q <= 1'b1;
                fb_idx_q   <= cur_q;
            end
        end
    end

    // Victim result registers; victim_valid is a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_idx   <= '0;
            victim_dirty <= 1'b0;
        end else begin
            victim_valid <= pick;
            if (pick) begin
                victim_idx   <= pick_idx;
                victim_dirty <= dirty_vec[pick_idx];
            end
        end
    end

    p_victim_after_sweep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> ($past(state_q) == ST_SWEEP));

    p_victim_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid);

    p_busy_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && repl_req) |=> busy);

    p_clean_pick_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pick && clean_q && pick_idx == cur_q) |-> !cur_used);
endmodule

// File: rtl/clock_victim_selector.sv
// Top level of the clock page replacement selector.
// Joins the flag bank and the sweep controller. Reference strobes update the
// flags at all times; replacement requests are taken only while idle.
module clock_victim_selector #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic             ref_write,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             repl_req,
    input  logic             repl_clean,
    output logic             busy,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_dirty
);
    logic [NUM_FRAMES-1:0] used_vec;
    logic [NUM_FRAMES-1:0] dirty_vec;
    logic                  clr_used_en;
    logic [IDX_W-1:0]      clr_used_idx;
    logic                  evict_en;
    logic [IDX_W-1:0]      evict_idx;

    crp_flag_bank #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_write    (ref_write),
        .ref_idx      (ref_idx),
        .clr_used_en  (clr_used_en),
        .clr_used_idx (clr_used_idx),
        .evict_en     (evict_en),
        .evict_idx    (evict_idx),
        .used_vec     (used_vec),
        .dirty_vec    (dirty_vec)
    );

    crp_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .repl_req     (repl_req),
        .repl_clean   (repl_clean),
        .ref_valid    (ref_valid),
        .ref_idx      (ref_idx),
        .used_vec     (used_vec),
        .dirty_vec    (dirty_vec),
        .clr_used_en  (clr_used_en),
        .clr_used_idx (clr_used_idx),
        .evict_en     (evict_en),
        .evict_idx    (evict_idx),
        .busy         (busy),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .victim_dirty (victim_dirty)
    );

    p_no_victim_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !busy);
endmodule

// File: tb/clock_victim_selector_test.sv
// Scoreboard bench: the driver predicts each victim from a flag model and
// queues it; the monitor compares every victim_valid pulse against the queue.
module clock_victim_selector_test;
    localparam int N  = 8;
    localparam int IW = 3;

    typedef struct {
        int idx;
        int dirty;
        int cyc;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic          ref_write = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          repl_req = 1'b0;
    logic          repl_clean = 1'b0;
    logic          busy;
    logic          victim_valid;
    logic [IW-1:0] victim_idx;
    logic          victim_dirty;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    int   n_pushed = 0;
    int   n_seen   = 0;
    exp_t sb_q[$];

    bit   m_used [N];
    bit   m_dirty[N];
    int   m_ptr;

    clock_victim_selector #(.NUM_FRAMES(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_write(ref_write), .ref_idx(ref_idx),
        .repl_req(repl_req), .repl_clean(repl_clean),
        .busy(busy), .victim_valid(victim_valid),
        .victim_idx(victim_idx), .victim_dirty(victim_dirty)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Flag model of the requirements: predicts victim, modified bit, steps.
    task automatic model_pick(input bit clean, output int v, output int vd, output int st);
        int c;
        int fb;
        c  = m_ptr;
        st = 0;
        v  = -1;
        fb = -1;
        if (clean) begin
            for (int k = 0; k < N; k++) begin
                c = (c + 1) % N;
                st++;
                if (!m_used[c] && !m_dirty[c]) begin
                    v = c;
                    break;
                end
                if (!m_used[c] && fb < 0) fb = c;
                m_used[c] = 1'b0;
            end
            if (v < 0 && fb >= 0) v = fb;
        end
        while (v < 0) begin
            c = (c + 1) % N;
            st++;
            if (!m_used[c]) v = c;
            else m_used[c] = 1'b0;
        end
        vd = m_dirty[v];
        m_used[v]  = 1'b0;
        m_dirty[v] = 1'b0;
        m_ptr = v;
    endtask

    task automatic do_ref(input int idx, input bit wr);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_write = wr;
        ref_idx   = IW'(idx);
        m_used[idx] = 1'b1;
        if (wr) m_dirty[idx] = 1'b1;
        @(negedge clk);
        ref_valid = 1'b0;
        ref_write = 1'b0;
    endtask

    task automatic push_exp(input int v, input int vd, input int st);
        exp_t e;
        e.idx   = v;
        e.dirty = vd;
        e.cyc   = cyc + 1 + st;
        sb_q.push_back(e);
        n_pushed++;
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Issue one request; hold_extra keeps repl_req high while busy (R3).
    task automatic do_req(input bit clean, input int hold_extra);
        int v, vd, st;
        @(negedge clk);
        model_pick(clean, v, vd, st);
        push_exp(v, vd, st);
        repl_req   = 1'b1;
        repl_clean = clean;
        @(negedge clk);
        chk(busy === 1'b1, "R3 busy after accept", int'(busy), 1);
        for (int k = 0; k < hold_extra; k++) @(negedge clk);
        repl_req = 1'b0;
        wait_done();
    endtask

    // Request with a same-cycle reference to the first examined frame (R11).
    task automatic do_req_race();
        int v, vd, st, f1;
        @(negedge clk);
        f1 = (m_ptr + 1) % N;
        m_used[f1] = 1'b1;
        model_pick(1'b0, v, vd, st);
        m_used[f1] = 1'b1;
        push_exp(v, vd, st);
        repl_req   = 1'b1;
        repl_clean = 1'b0;
        @(negedge clk);
        repl_req  = 1'b0;
        ref_valid = 1'b1;
        ref_write = 1'b0;
        ref_idx   = IW'(f1);
        @(negedge clk);
        ref_valid = 1'b0;
        chk(v != f1, "R11 raced frame not chosen (model)", v, f1);
        wait_done();
    endtask

    // Monitor: compare every victim pulse against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && victim_valid) begin
            n_seen++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3 unexpected victim", int'(victim_idx), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(int'(victim_idx) == e.idx, "R5/R6/R9/R10/R11 victim index", int'(victim_idx), e.idx);
                chk(int'(victim_dirty) == e.dirty, "R8 victim modified flag", int'(victim_dirty), e.dirty);
                chk(cyc == e.cyc, "R4 victim timing", cyc, e.cyc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_used[i]  = 1'b0;
            m_dirty[i] = 1'b0;
        end
        m_ptr = N - 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(victim_valid === 1'b0, "R1 victim_valid after reset", int'(victim_valid), 0);

        // R1/R4: first basic sweep starts at frame 0
        do_req(1'b0, 0);

        // R2/R5: used frames skipped and cleared
        do_ref(1, 1'b0);
        do_ref(2, 1'b1);
        do_ref(3, 1'b0);
        do_req(1'b0, 0);

        // R6/R8: all used, hand wraps, victim after N+1 frames, modified reported
        for (int i = 0; i < N; i++) do_ref(i, i == 5);
        do_req(1'b0, 0);

        // R7: victim flags cleared and hand rests on victim
        do_ref(6, 1'b1);
        do_ref(7, 1'b1);
        do_req(1'b0, 0);

        // R9: clean-preferred skips unused modified frames
        do_ref(1, 1'b0);
        do_req(1'b1, 0);

        // R10: only modified frames unused, fallback to first unused
        for (int i = 0; i < N; i++) do_ref(i, 1'b1);
        do_req(1'b0, 0);
        do_ref(m_ptr, 1'b1);
        do_req(1'b1, 0);

        // R10: clean-preferred with every frame used continues in basic mode
        for (int i = 0; i < N; i++) do_ref(i, 1'b1);
        do_req(1'b1, 0);

        // R11: same-cycle reference keeps the examined frame's used flag
        do_req_race();
        do_req(1'b0, 0);
        do_req(1'b0, 0);

        // R3: requests held during a long sweep are ignored
        for (int i = 0; i < N; i++) do_ref(i, 1'b0);
        do_req(1'b0, 4);
        repeat (3) @(negedge clk);
        chk(n_seen == n_pushed, "R3 victim count", n_seen, n_pushed);
        chk(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule